// File: doc/BRIEF.md
# Two-Stage Receive Byte Buffer

This block holds received bytes for a byte-oriented serial bus controller on their way to software. The protocol engine hands each completed byte over with a one-cycle strobe. The byte lands in a shift stage. From there it moves on its own into a holding buffer, which is what software sees. Software has two ways to read it. A popping read returns the held byte and frees the slot. A peek returns the same value and changes nothing.

A pop that finds the holding buffer empty returns zero and raises a one-cycle underflow pulse. Each forward move of a byte raises a one-cycle data-valid pulse, and a status level shows that the holding buffer is occupied. When both stages are occupied, the block raises a bus-hold level so that the engine stops clocking in more data, and a one-cycle bus-hold pulse marks the moment the hold begins. Clearing the enable input empties both stages at the next edge.

Top module: `rx_hold_buffer`

## Requirements
- R1: After reset, dataValid, busHold and every pulse output are low, and both popData and peekData read zero.
- R2: A pop while the holding buffer is empty presents zero on popData in that cycle. underflowIrq is high for exactly the cycle after that edge.
- R3: A byte strobed into an empty block reaches the holding buffer at the second clock edge. From that edge on, dataValid is high and peekData shows the byte, and rxValidIrq is high for the one cycle after the move.
- R4: Holding peekData over any number of cycles leaves the held byte, dataValid and the order of later pops unchanged.
- R5: A pop while the holding buffer is full presents the held byte on popData in that cycle. If the shift stage is empty, dataValid falls and peekData reads zero after the edge.
- R6: When both stages are occupied, busHold is high. busHoldIrq is high for the one cycle after the edge at which the second stage fills.
- R7: A byte strobe arriving while the shift stage is occupied is dropped. It never appears on a later pop.
- R8: A pop while both stages are full moves the pending byte into the holding buffer at the same edge. After that edge busHold is low, dataValid stays high, peekData shows the pending byte, and rxValidIrq pulses.
- R9: A cycle with enable low empties both stages. After that edge dataValid and busHold are low and a pop underflows.
- R10: A byte strobe arriving while enable is low is not stored.
- R11: A pop of a full holding buffer and a byte strobe into an empty shift stage in the same cycle both take effect. The popped byte is returned and the new byte follows on the next pop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Controller enable; low empties both stages |
| inValid | input | 1 | One-cycle strobe: a received byte is present |
| inByte | input | DATA_W | Received byte |
| popRd | input | 1 | Consuming read of the holding buffer |
| popData | output | DATA_W | Value returned by the consuming read |
| peekData | output | DATA_W | Non-destructive view of the holding buffer |
| dataValid | output | 1 | Holding buffer occupied |
| busHold | output | 1 | Both stages occupied; upstream must stall |
| rxValidIrq | output | 1 | Pulse: a byte moved into the holding buffer |
| underflowIrq | output | 1 | Pulse: pop found the holding buffer empty |
| busHoldIrq | output | 1 | Pulse: bus hold has just begun |

## Verification
The consuming read can fall in the same cycle as two other events. One is the forward move of a pending byte out of the shift stage. The other is a new byte strobe arriving from the engine. The bench provokes the first by popping while busHold is high. It provokes the second by raising popRd and inValid at the same falling edge while one byte is held. A scoreboard queue carries the accepted bytes in arrival order, and every pop is compared against the queue's head, or against zero when the queue is empty. This shows whether both events took effect without one masking the other.

// File: rtl/rxhb_pkg.sv
package rxhb_pkg;

  // strobes from the control FSM to the datapath, one cycle each
  typedef struct packed {
    logic loadShift;  // capture inByte into the shift stage
    logic moveHold;   // shift stage -> holding buffer
    logic clearHold;  // holding buffer emptied by a pop
    logic clearAll;   // controller disabled
  } rxhbStrobes_t;

endpackage

// File: rtl/rxhb_ctrl.sv
module rxhb_ctrl
  import rxhb_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         enable,
  input  logic         inValid,
  input  logic         popRd,
  output rxhbStrobes_t stb,
  output logic         holdFull,
  output logic         shiftFull,
  output logic         rxValidIrq,
  output logic         underflowIrq,
  output logic         busHoldIrq
);

  logic popHit, popMiss;
  logic shiftFullNext, holdFullNext;
  logic bothNow, bothNext;

  always_comb begin
    popHit        = popRd & holdFull & enable;
    popMiss       = popRd & ~(holdFull & enable);
    stb.clearAll  = ~enable;
    stb.loadShift = enable & inValid & ~shiftFull;
    stb.moveHold  = enable & shiftFull & (~holdFull | popHit);
    stb.clearHold = popHit & ~stb.moveHold;

    shiftFullNext = shiftFull;
    if (stb.loadShift)     shiftFullNext = 1'b1;
    else if (stb.moveHold) shiftFullNext = 1'b0;
    if (stb.clearAll)      shiftFullNext = 1'b0;

    holdFullNext = holdFull;
    if (stb.moveHold)       holdFullNext = 1'b1;
    else if (stb.clearHold) holdFullNext = 1'b0;
    if (stb.clearAll)       holdFullNext = 1'b0;

    bothNow  = shiftFull & holdFull;
    bothNext = shiftFullNext & holdFullNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftFull    <= 1'b0;
      holdFull     <= 1'b0;
      rxValidIrq   <= 1'b0;
      underflowIrq <= 1'b0;
      busHoldIrq   <= 1'b0;
    end else begin
      shiftFull    <= shiftFullNext;
      holdFull     <= holdFullNext;
      rxValidIrq   <= stb.moveHold;
      underflowIrq <= popMiss;
      busHoldIrq   <= bothNext & ~bothNow;
    end
  end

endmodule

// File: rtl/rxhb_datapath.sv
module rxhb_datapath
  import rxhb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxhbStrobes_t      stb,
  input  logic [DATA_W-1:0] inByte,
  output logic [DATA_W-1:0] holdByte
);

  logic [DATA_W-1:0] shiftByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftByte <= '0;
    end else if (stb.clearAll) begin
      shiftByte <= '0;
    end else if (stb.loadShift) begin
      shiftByte <= inByte;
    end else if (stb.moveHold) begin
      shiftByte <= '0;
    end
  end

  // an empty holding buffer always holds zero, so reads of it return zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdByte <= '0;
    end else if (stb.clearAll) begin
      holdByte <= '0;
    end else if (stb.moveHold) begin
      holdByte <= shiftByte;
    end else if (stb.clearHold) begin
      holdByte <= '0;
    end
  end

endmodule

// File: rtl/rx_hold_buffer.sv
module rx_hold_buffer
  import rxhb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inByte,
  input  logic              popRd,
  output logic [DATA_W-1:0] popData,
  output logic [DATA_W-1:0] peekData,
  output logic              dataValid,
  output logic              busHold,
  output logic              rxValidIrq,
  output logic              underflowIrq,
  output logic              busHoldIrq
);

  rxhbStrobes_t      stb;
  logic              holdFull, shiftFull;
  logic [DATA_W-1:0] holdByte;

  rxhb_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .enable       (enable),
    .inValid      (inValid),
    .popRd        (popRd),
    .stb          (stb),
    .holdFull     (holdFull),
    .shiftFull    (shiftFull),
    .rxValidIrq   (rxValidIrq),
    .underflowIrq (underflowIrq),
    .busHoldIrq   (busHoldIrq)
  );

  rxhb_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .inByte   (inByte),
    .holdByte (holdByte)
  );

  assign popData   = holdByte;
  assign peekData  = holdByte;
  assign dataValid = holdFull;
  assign busHold   = holdFull & shiftFull;

endmodule

// File: rtl/rxhb_checker.sv
module rxhb_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              popRd,
  input logic [DATA_W-1:0] peekData,
  input logic              dataValid,
  input logic              busHold,
  input logic              rxValidIrq,
  input logic              underflowIrq
);

  a_r2_underflow_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (popRd && !dataValid) |=> underflowIrq);

  a_r3_valid_after_move: assert property (@(posedge clk) disable iff (!rstN)
    rxValidIrq |-> dataValid);

  a_r5_empty_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    !dataValid |-> (peekData == '0));

  a_r6_hold_implies_full: assert property (@(posedge clk) disable iff (!rstN)
    busHold |-> dataValid);

  a_r7_hold_keeps_byte: assert property (@(posedge clk) disable iff (!rstN)
    (busHold && !popRd && enable) |=> ($stable(peekData) && busHold));

  a_r9_disable_empties: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!dataValid && !busHold));

endmodule

bind rx_hold_buffer rxhb_checker #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .enable       (enable),
  .popRd        (popRd),
  .peekData     (peekData),
  .dataValid    (dataValid),
  .busHold      (busHold),
  .rxValidIrq   (rxValidIrq),
  .underflowIrq (underflowIrq)
);

// File: tb/rx_hold_buffer_bench.sv
`timescale 1ns/100ps
module rx_hold_buffer_bench;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          enable = 1'b0;
  logic          inValid = 1'b0;
  logic [DW-1:0] inByte = '0;
  logic          popRd = 1'b0;
  logic [DW-1:0] popData, peekData;
  logic          dataValid, busHold, rxValidIrq, underflowIrq, busHoldIrq;

  always #2.5 clk = ~clk;

  rx_hold_buffer #(.DATA_W(DW)) u_rx_hold_buffer (
    .clk(clk), .rstN(rstN), .enable(enable), .inValid(inValid), .inByte(inByte),
    .popRd(popRd), .popData(popData), .peekData(peekData), .dataValid(dataValid),
    .busHold(busHold), .rxValidIrq(rxValidIrq), .underflowIrq(underflowIrq),
    .busHoldIrq(busHoldIrq)
  );

  int total = 0;
  int bad = 0;
  logic [DW-1:0] expQ[$];
  string popTag = "R5";
  logic  bhSeen, dvEnd, ufSeen, dvSeen;
  bit    done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: every pop is compared with the scoreboard head (or zero)
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (popRd) begin
        logic [DW-1:0] e;
        e = (expQ.size() != 0) ? expQ.pop_front() : '0;
        check(popData == e, popTag, popData, e);
      end
    end
  end

  task automatic pushByte(input logic [DW-1:0] b);
    bit acc;
    acc = (expQ.size() < 2) && enable;
    @(negedge clk);
    inValid = 1'b1;
    inByte  = b;
    if (acc) expQ.push_back(b);
    @(negedge clk);
    inValid = 1'b0;
    bhSeen  = busHoldIrq;
    @(negedge clk);
    dvEnd = rxValidIrq;
  endtask

  task automatic popOne(input string tag);
    @(negedge clk);
    popTag = tag;
    popRd  = 1'b1;
    @(negedge clk);
    popRd  = 1'b0;
    ufSeen = underflowIrq;
    dvSeen = rxValidIrq;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check(dataValid == 0, "R1", dataValid, 0);
    check(busHold == 0, "R1", busHold, 0);
    check({rxValidIrq, underflowIrq, busHoldIrq} == 0, "R1",
          {rxValidIrq, underflowIrq, busHoldIrq}, 0);
    check(peekData == 0 && popData == 0, "R1", peekData, 0);
    rstN = 1'b1;
    enable = 1'b1;

    // R2 underflow on empty pop
    popOne("R2");
    check(ufSeen == 1, "R2", ufSeen, 1);
    check(dvSeen == 0, "R2", dvSeen, 0);

    // R3 byte moves to holding buffer
    pushByte(8'hA5);
    check(dataValid == 1, "R3", dataValid, 1);
    check(peekData == 8'hA5, "R3", peekData, 8'hA5);
    check(dvEnd == 1, "R3", dvEnd, 1);

    // R4 peek is non-destructive
    repeat (4) @(negedge clk);
    check(peekData == 8'hA5, "R4", peekData, 8'hA5);
    check(dataValid == 1, "R4", dataValid, 1);

    // R5 pop returns byte and empties
    popOne("R5");
    check(dataValid == 0, "R5", dataValid, 0);
    check(peekData == 0, "R5", peekData, 0);
    check(ufSeen == 0, "R5", ufSeen, 0);

    // R6 both stages full
    pushByte(8'h11);
    pushByte(8'h22);
    check(busHold == 1, "R6", busHold, 1);
    check(bhSeen == 1, "R6", bhSeen, 1);
    check(peekData == 8'h11, "R6", peekData, 8'h11);

    // R7 strobe while shift stage full is dropped
    pushByte(8'h33);
    check(busHold == 1, "R7", busHold, 1);
    check(peekData == 8'h11, "R7", peekData, 8'h11);

    // R8 pop while both full refills and releases hold
    popOne("R8");
    check(dvSeen == 1, "R8", dvSeen, 1);
    check(busHold == 0, "R8", busHold, 0);
    check(dataValid == 1, "R8", dataValid, 1);
    check(peekData == 8'h22, "R8", peekData, 8'h22);
    popOne("R8");
    popOne("R7");
    check(ufSeen == 1, "R7", ufSeen, 1);

    // R11 pop and strobe in the same cycle
    pushByte(8'h44);
    @(negedge clk);
    popTag  = "R11";
    popRd   = 1'b1;
    inValid = 1'b1;
    inByte  = 8'h55;
    expQ.push_back(8'h55);
    @(negedge clk);
    popRd   = 1'b0;
    inValid = 1'b0;
    @(negedge clk);
    check(dataValid == 1, "R11", dataValid, 1);
    check(peekData == 8'h55, "R11", peekData, 8'h55);
    popOne("R11");

    // R9 disable empties both stages
    pushByte(8'h66);
    pushByte(8'h77);
    @(negedge clk);
    enable = 1'b0;
    expQ.delete();
    @(negedge clk);
    check(dataValid == 0, "R9", dataValid, 0);
    check(busHold == 0, "R9", busHold, 0);

    // R10 strobe while disabled is not stored
    pushByte(8'h88);
    enable = 1'b1;
    repeat (2) @(negedge clk);
    check(dataValid == 0, "R10", dataValid, 0);
    check(peekData == 0, "R10", peekData, 0);
    popOne("R9");
    check(ufSeen == 1, "R9", ufSeen, 1);

    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule